// File: doc/BRIEF.md
# Trap Return-Frame Sequencer

This block builds the stack frame that a processor core leaves behind when it takes an exception or an interrupt, and takes that frame apart again when the handler executes its interrupt-return. When a trap is requested, the block copies the current code selector, instruction offset, flags and stack pointer. It then issues one stack write per cycle. The writes go to successively lower addresses, and each write address is the stack pointer after that push. When the frame is complete, the block pulses `done` and presents the new stack pointer.

The width of the frame depends on the operating mode. In real mode every slot is 16 bits wide. The saved instruction offset is cut to its low half, so an offset that has run past 64K is saved as a small value. Real-mode exceptions never push an error code. Real-mode stack arithmetic also wraps inside the low 16 bits of the stack pointer. In protected mode, a 32-bit gate produces 32-bit slots that hold the full offset, and a 16-bit gate produces 16-bit slots. In both protected cases the exception vectors that carry a fault code push one.

On interrupt-return the block reads three slots back. These are the offset, then the selector, then the flags. The stack pointer rises after each read. In protected mode, a restored offset above the code-segment limit is reported as a fault. On a fault the stack pointer is left as it was before the return. Descriptor lookups, privilege changes and interrupt routing belong to other blocks.

Top module: `trap_frame_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge the block becomes idle: `busy`, `done`, `ret_fault`, `wr_en` and `rd_en` are 0 and `sp_new` is 0.
- R2: A `trap_req` sampled while idle starts the frame. In the cycles after that edge the block writes, one slot per cycle, first the flags, then the code selector (zero-extended), then the instruction offset. Each `wr_addr` is the stack pointer after that push has been decremented.
- R3: In real mode (`prot_mode`=0) every slot is 16 bits (`wr_size`=0, upper 16 data bits zero). The offset is saved as its low 16 bits, so 0x00010000 is saved as 0x0000. No error code is pushed for any vector, including vector 13.
- R4: In protected mode with `gate32`=1 every slot is 32 bits (`wr_size`=1) and the full 32-bit offset is saved. Vectors 8, 10, 11, 12, 13, 14 and 17 add a fourth write holding `trap_err`. No other vector adds one, and no vector of 32 or above adds one.
- R5: In protected mode with `gate32`=0 every slot is 16 bits, and an error code, when pushed, is its low 16 bits.
- R6: The stride is 2 for 16-bit slots and 4 for 32-bit slots. In real mode only the low 16 bits of the stack pointer move, wrapping modulo 64K, and the upper 16 bits are kept. In protected mode the full 32-bit value moves.
- R7: `done` is a one-cycle pulse in the cycle after the last stack access: cycle N+1 after the request edge for a frame of N slots. While `done` is high, `sp_new` holds the final stack pointer.
- R8: `trap_req` and `iret_req` have no effect while `busy`, which includes the `done` cycle. The values captured at the start are used for the whole frame. When both requests arrive together while idle, the trap is taken.
- R9: An `iret_req` sampled while idle reads three slots, one per cycle: offset, then selector, then flags. `rd_addr` is the stack pointer before each increment. Values from 16-bit frames are zero-extended into `ret_eip`, `ret_cs` and `ret_flags`. `sp_new` is then the original pointer plus three strides.
- R10: In protected mode, if the restored offset exceeds `cs_limit`, `ret_fault` is high together with `done`, and `sp_new` equals the stack pointer given with the return request.
- R11: In real mode the interrupt return never raises `ret_fault`, whatever `cs_limit` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Start building a trap frame |
| trap_vec | input | VEC_W | Vector number of the trap |
| trap_err | input | WORD_W | Fault code for vectors that carry one |
| iret_req | input | 1 | Start an interrupt return |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| gate32 | input | 1 | 1 = 32-bit gate or return size (protected mode only) |
| cur_cs | input | SEL_W | Current code selector |
| cur_eip | input | WORD_W | Current instruction offset |
| cur_flags | input | WORD_W | Current flags |
| cur_sp | input | WORD_W | Current stack pointer |
| cs_limit | input | WORD_W | Code-segment limit checked on return |
| rd_data | input | WORD_W | Stack read data, valid in the cycle of `rd_en` |
| wr_en | output | 1 | Stack write strobe |
| wr_addr | output | WORD_W | Stack write address |
| wr_data | output | WORD_W | Stack write data |
| wr_size | output | 1 | 0 = 16-bit slot, 1 = 32-bit slot |
| rd_en | output | 1 | Stack read strobe |
| rd_addr | output | WORD_W | Stack read address |
| rd_size | output | 1 | 0 = 16-bit slot, 1 = 32-bit slot |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ret_fault | output | 1 | Protection fault on return, valid with `done` |
| sp_new | output | WORD_W | Resulting stack pointer, valid with `done` |
| ret_eip | output | WORD_W | Restored instruction offset |
| ret_cs | output | SEL_W | Restored code selector |
| ret_flags | output | WORD_W | Restored flags |

## Verification
A wrong step counter or a wrong captured mode shows up on the very next stack write. The bench catches it as a misordered slot, a wrong width or a missing or extra error-code write. It also catches a bad stride between consecutive addresses. A stack pointer that is corrupted mid-frame shows up as a shifted address one cycle later and as a wrong `sp_new` at `done`. A fault decision made against the wrong slot shows up only in the `done` cycle of the return, as a wrong `ret_fault` or an unrestored `sp_new`.

// File: rtl/tf_pkg.sv
// Shared types of the trap frame sequencer.
// Assumes: four sequencer states and at most four frame slots.
package tf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_POP  = 2'd2,
        ST_FIN  = 2'd3
    } tf_state_e;

    // Slot numbers: push order, lowest first.
    localparam logic [1:0] SLOT_FLAGS = 2'd0;
    localparam logic [1:0] SLOT_CS    = 2'd1;
    localparam logic [1:0] SLOT_IP    = 2'd2;
    localparam logic [1:0] SLOT_ERR   = 2'd3;

    // Mode captured at the start of a sequence.
    typedef struct packed {
        logic prot;
        logic wide;
        logic with_err;
    } tf_mode_t;

endpackage

// File: rtl/tf_err_map.sv
// Decides whether a trap vector pushes a fault code.
// Assumes: only vectors below 32 can carry one, and only in protected mode.
module tf_err_map #(
    parameter int          VEC_W    = 8,
    parameter logic [31:0] ERR_MASK = 32'h0002_7D00
) (
    input  logic             prot,
    input  logic [VEC_W-1:0] vec,
    output logic             with_err
);
    localparam int IDX_W = 5;

    logic             in_range;
    logic [IDX_W-1:0] idx;

    // Pick the range test that fits the vector width.
    generate
        if (VEC_W > IDX_W) begin : g_wide_vec
            assign in_range = ~|vec[VEC_W-1:IDX_W];
            assign idx      = vec[IDX_W-1:0];
        end else begin : g_narrow_vec
            assign in_range = 1'b1;
            assign idx      = IDX_W'(vec);
        end
    endgenerate

    // Fault code only for listed exception vectors in protected mode.
    always_comb begin
        with_err = prot && in_range && ERR_MASK[idx];
    end

endmodule

// File: rtl/tf_sp_step.sv
// Computes the stack pointer one slot down and one slot up.
// Assumes: stride 2 for narrow slots and 4 for wide ones; real mode moves
// only the low half of the pointer and keeps the high half.
module tf_sp_step #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] sp,
    input  logic              real_mode,
    input  logic              wide,
    output logic [WORD_W-1:0] sp_dn,
    output logic [WORD_W-1:0] sp_up
);
    localparam int HW = WORD_W / 2;

    logic [WORD_W-1:0] stride;
    logic [HW-1:0]     low_dn;
    logic [HW-1:0]     low_up;

    // Slot stride from frame width.
    always_comb begin
        stride = wide ? WORD_W'(4) : WORD_W'(2);
    end

    // Low-half arithmetic wraps modulo the real-mode segment size.
    always_comb begin
        low_dn = sp[HW-1:0] - stride[HW-1:0];
        low_up = sp[HW-1:0] + stride[HW-1:0];
    end

    // Select wrapped or full-width result by mode.
    always_comb begin
        if (real_mode) begin
            sp_dn = {sp[WORD_W-1:HW], low_dn};
            sp_up = {sp[WORD_W-1:HW], low_up};
        end else begin
            sp_dn = sp - stride;
            sp_up = sp + stride;
        end
    end

endmodule

// File: rtl/tf_slot_sel.sv
// Chooses the value for the current push slot and trims it to the slot width.
// Assumes: the selector is zero-extended; narrow slots keep the low half.
module tf_slot_sel #(
    parameter int WORD_W = 32,
    parameter int SEL_W  = 16
) (
    input  logic [1:0]        slot,
    input  logic              wide,
    input  logic [WORD_W-1:0] flags,
    input  logic [SEL_W-1:0]  cs,
    input  logic [WORD_W-1:0] eip,
    input  logic [WORD_W-1:0] err,
    output logic [WORD_W-1:0] data
);
    import tf_pkg::*;

    localparam int HW = WORD_W / 2;

    logic [WORD_W-1:0] raw;

    // Slot order multiplexer.
    always_comb begin
        case (slot)
            SLOT_FLAGS: raw = flags;
            SLOT_CS:    raw = WORD_W'(cs);
            SLOT_IP:    raw = eip;
            default:    raw = err;
        endcase
    end

    // Narrow slots drop the high half.
    always_comb begin
        data = wide ? raw : {{(WORD_W-HW){1'b0}}, raw[HW-1:0]};
    end

endmodule

// File: rtl/tf_ctl.sv
// Sequencer state machine: captures the request, steps through the slots,
// collects popped values and decides the return fault.
// Assumes: rd_data is valid in the same cycle as the read strobe; requests
// are only looked at while idle; a trap request wins over a return request.
module tf_ctl #(
    parameter int WORD_W = 32,
    parameter int SEL_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trap_req,
    input  logic                with_err,
    input  logic                iret_req,
    input  logic                prot_mode,
    input  logic                gate32,
    input  logic [SEL_W-1:0]    cur_cs,
    input  logic [WORD_W-1:0]   cur_eip,
    input  logic [WORD_W-1:0]   cur_flags,
    input  logic [WORD_W-1:0]   cur_sp,
    input  logic [WORD_W-1:0]   cur_err,
    input  logic [WORD_W-1:0]   cs_limit,
    input  logic [WORD_W-1:0]   rd_data,
    input  logic [WORD_W-1:0]   sp_dn,
    input  logic [WORD_W-1:0]   sp_up,
    output tf_pkg::tf_state_e   st,
    output logic [1:0]          slot,
    output tf_pkg::tf_mode_t    mode,
    output logic [WORD_W-1:0]   sp_cur,
    output logic [WORD_W-1:0]   snap_flags,
    output logic [SEL_W-1:0]    snap_cs,
    output logic [WORD_W-1:0]   snap_eip,
    output logic [WORD_W-1:0]   snap_err,
    output logic [WORD_W-1:0]   ret_eip,
    output logic [SEL_W-1:0]    ret_cs,
    output logic [WORD_W-1:0]   ret_flags,
    output logic                fault_r
);
    import tf_pkg::*;

    localparam int HW = WORD_W / 2;

    logic [1:0]        last_slot;
    logic [WORD_W-1:0] sp_orig;
    logic [WORD_W-1:0] limit_r;
    logic [WORD_W-1:0] pop_val;

    // Popped value trimmed to the frame width.
    always_comb begin
        pop_val = mode.wide ? rd_data : {{(WORD_W-HW){1'b0}}, rd_data[HW-1:0]};
    end

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            slot       <= 2'd0;
            last_slot  <= 2'd0;
            mode       <= '0;
            sp_cur     <= '0;
            sp_orig    <= '0;
            limit_r    <= '0;
            snap_flags <= '0;
            snap_cs    <= '0;
            snap_eip   <= '0;
            snap_err   <= '0;
            ret_eip    <= '0;
            ret_cs     <= '0;
            ret_flags  <= '0;
            fault_r    <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (trap_req) begin
                        mode.prot     <= prot_mode;
                        mode.wide     <= prot_mode && gate32;
                        mode.with_err <= with_err;
                        last_slot     <= with_err ? SLOT_ERR : SLOT_IP;
                        snap_flags    <= cur_flags;
                        snap_cs       <= cur_cs;
                        snap_eip      <= cur_eip;
                        snap_err      <= cur_err;
                        sp_cur        <= cur_sp;
                        slot          <= SLOT_FLAGS;
                        fault_r       <= 1'b0;
                        st            <= ST_PUSH;
                    end else if (iret_req) begin
                        mode.prot     <= prot_mode;
                        mode.wide     <= prot_mode && gate32;
                        mode.with_err <= 1'b0;
                        limit_r       <= cs_limit;
                        sp_cur        <= cur_sp;
                        sp_orig       <= cur_sp;
                        slot          <= 2'd0;
                        fault_r       <= 1'b0;
                        st            <= ST_POP;
                    end
                end
                ST_PUSH: begin
                    sp_cur <= sp_dn;
                    if (slot == last_slot) begin
                        st <= ST_FIN;
                    end else begin
                        slot <= slot + 2'd1;
                    end
                end
                ST_POP: begin
                    sp_cur <= sp_up;
                    case (slot)
                        2'd0: begin
                            ret_eip <= pop_val;
                            slot    <= 2'd1;
                        end
                        2'd1: begin
                            ret_cs <= pop_val[SEL_W-1:0];
                            slot   <= 2'd2;
                        end
                        default: begin
                            ret_flags <= pop_val;
                            if (mode.prot && (ret_eip > limit_r)) begin
                                fault_r <= 1'b1;
                                sp_cur  <= sp_orig;
                            end
                            st <= ST_FIN;
                        end
                    endcase
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/trap_frame_engine.sv
// Top level of the trap frame sequencer: builds the return frame on a
// trap and unwinds it on an interrupt return.
// Assumes: one stack access per cycle, reads answered in the same cycle,
// and no segment base added to stack addresses.
module trap_frame_engine #(
    parameter int          VEC_W    = 8,
    parameter int          WORD_W   = 32,
    parameter int          SEL_W    = 16,
    parameter logic [31:0] ERR_MASK = 32'h0002_7D00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic [VEC_W-1:0]  trap_vec,
    input  logic [WORD_W-1:0] trap_err,
    input  logic              iret_req,
    input  logic              prot_mode,
    input  logic              gate32,
    input  logic [SEL_W-1:0]  cur_cs,
    input  logic [WORD_W-1:0] cur_eip,
    input  logic [WORD_W-1:0] cur_flags,
    input  logic [WORD_W-1:0] cur_sp,
    input  logic [WORD_W-1:0] cs_limit,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_size,
    output logic              rd_en,
    output logic [WORD_W-1:0] rd_addr,
    output logic              rd_size,
    output logic              busy,
    output logic              done,
    output logic              ret_fault,
    output logic [WORD_W-1:0] sp_new,
    output logic [WORD_W-1:0] ret_eip,
    output logic [SEL_W-1:0]  ret_cs,
    output logic [WORD_W-1:0] ret_flags
);
    import tf_pkg::*;

    logic              with_err;
    tf_state_e         st;
    logic [1:0]        slot;
    tf_mode_t          mode;
    logic [WORD_W-1:0] sp_cur;
    logic [WORD_W-1:0] sp_dn;
    logic [WORD_W-1:0] sp_up;
    logic [WORD_W-1:0] snap_flags;
    logic [SEL_W-1:0]  snap_cs;
    logic [WORD_W-1:0] snap_eip;
    logic [WORD_W-1:0] snap_err;
    logic [WORD_W-1:0] slot_data;
    logic              fault_r;

    tf_err_map #(
        .VEC_W    (VEC_W),
        .ERR_MASK (ERR_MASK)
    ) u_err_map (
        .prot     (prot_mode),
        .vec      (trap_vec),
        .with_err (with_err)
    );

    tf_sp_step #(
        .WORD_W (WORD_W)
    ) u_sp_step (
        .sp        (sp_cur),
        .real_mode (!mode.prot),
        .wide      (mode.wide),
        .sp_dn     (sp_dn),
        .sp_up     (sp_up)
    );

    tf_slot_sel #(
        .WORD_W (WORD_W),
        .SEL_W  (SEL_W)
    ) u_slot_sel (
        .slot  (slot),
        .wide  (mode.wide),
        .flags (snap_flags),
        .cs    (snap_cs),
        .eip   (snap_eip),
        .err   (snap_err),
        .data  (slot_data)
    );

    tf_ctl #(
        .WORD_W (WORD_W),
        .SEL_W  (SEL_W)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_req   (trap_req),
        .with_err   (with_err),
        .iret_req   (iret_req),
        .prot_mode  (prot_mode),
        .gate32     (gate32),
        .cur_cs     (cur_cs),
        .cur_eip    (cur_eip),
        .cur_flags  (cur_flags),
        .cur_sp     (cur_sp),
        .cur_err    (trap_err),
        .cs_limit   (cs_limit),
        .rd_data    (rd_data),
        .sp_dn      (sp_dn),
        .sp_up      (sp_up),
        .st         (st),
        .slot       (slot),
        .mode       (mode),
        .sp_cur     (sp_cur),
        .snap_flags (snap_flags),
        .snap_cs    (snap_cs),
        .snap_eip   (snap_eip),
        .snap_err   (snap_err),
        .ret_eip    (ret_eip),
        .ret_cs     (ret_cs),
        .ret_flags  (ret_flags),
        .fault_r    (fault_r)
    );

    // Stack port and status outputs from sequencer state.
    always_comb begin
        busy      = (st != ST_IDLE);
        done      = (st == ST_FIN);
        ret_fault = (st == ST_FIN) && fault_r;
        wr_en     = (st == ST_PUSH);
        wr_addr   = sp_dn;
        wr_data   = slot_data;
        wr_size   = mode.wide;
        rd_en     = (st == ST_POP);
        rd_addr   = sp_cur;
        rd_size   = mode.wide;
        sp_new    = sp_cur;
    end

endmodule

// File: rtl/tf_chk.sv
// Port-level protocol checks for the trap frame sequencer, bound to the top.
// Assumes: the stack-pointer stride is checked modulo the real-mode half width,
// which holds in both modes.
module tf_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic              wr_size,
    input logic              rd_en,
    input logic [WORD_W-1:0] rd_addr,
    input logic              rd_size,
    input logic              busy,
    input logic              done,
    input logic              ret_fault
);
    localparam int HW = WORD_W / 2;

    // R1: no stack traffic while idle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_en && !rd_en));

    // R9: reads and writes never share a cycle.
    p_port_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

    // R6: consecutive pushes step down by one slot.
    p_push_stride_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |->
            (HW'($past(wr_addr) - wr_addr) == (wr_size ? HW'(4) : HW'(2))));

    // R9: consecutive pops step up by one slot.
    p_pop_stride_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |->
            (HW'(rd_addr - $past(rd_addr)) == (rd_size ? HW'(4) : HW'(2))));

    // R3: narrow slots carry nothing in the high half.
    p_narrow_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_size) |-> (wr_data[WORD_W-1:HW] == '0));

    // R7: done lasts one cycle.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the done cycle is followed by idle.
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R10: a return fault is only reported with done.
    p_fault_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fault |-> done);

endmodule

bind trap_frame_engine tf_chk #(
    .WORD_W (WORD_W)
) u_tf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_size   (wr_size),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_size   (rd_size),
    .busy      (busy),
    .done      (done),
    .ret_fault (ret_fault)
);

// File: tb/trap_frame_engine_test.sv
`timescale 1ns/1ps
// Scoreboard bench: trap tasks queue the expected stack writes and a monitor
// compares each write as it appears; returns are checked at done.
module trap_frame_engine_test;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic        sz;
        string       tag;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic [7:0]  trap_vec = '0;
    logic [31:0] trap_err = '0;
    logic        iret_req = 1'b0;
    logic        prot_mode = 1'b0;
    logic        gate32 = 1'b0;
    logic [15:0] cur_cs = '0;
    logic [31:0] cur_eip = '0;
    logic [31:0] cur_flags = '0;
    logic [31:0] cur_sp = '0;
    logic [31:0] cs_limit = '0;
    logic [31:0] rd_data = '0;
    logic        wr_en;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_size;
    logic        rd_en;
    logic [31:0] rd_addr;
    logic        rd_size;
    logic        busy;
    logic        done;
    logic        ret_fault;
    logic [31:0] sp_new;
    logic [31:0] ret_eip;
    logic [15:0] ret_cs;
    logic [31:0] ret_flags;

    wr_item_t    exp_q[$];
    wr_item_t    mon_it;
    logic [7:0]  mem [logic [31:0]];
    int          total = 0;
    int          bad = 0;
    int          rd_cycles = 0;

    always #4 clk = ~clk;

    trap_frame_engine uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .trap_req  (trap_req),
        .trap_vec  (trap_vec),
        .trap_err  (trap_err),
        .iret_req  (iret_req),
        .prot_mode (prot_mode),
        .gate32    (gate32),
        .cur_cs    (cur_cs),
        .cur_eip   (cur_eip),
        .cur_flags (cur_flags),
        .cur_sp    (cur_sp),
        .cs_limit  (cs_limit),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_size   (wr_size),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_size   (rd_size),
        .busy      (busy),
        .done      (done),
        .ret_fault (ret_fault),
        .sp_new    (sp_new),
        .ret_eip   (ret_eip),
        .ret_cs    (ret_cs),
        .ret_flags (ret_flags)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rdb(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    task automatic put16(input logic [31:0] a, input logic [15:0] v);
        mem[a]      = v[7:0];
        mem[a + 1]  = v[15:8];
    endtask

    // Reference stack-pointer step: real mode wraps in the low half.
    function automatic logic [31:0] mdl_step(input logic [31:0] s, input bit prot,
                                             input int w, input bit up);
        logic [15:0] lo;
        if (prot) return up ? s + 32'(w) : s - 32'(w);
        lo = up ? s[15:0] + 16'(w) : s[15:0] - 16'(w);
        return {s[31:16], lo};
    endfunction

    function automatic bit mdl_err(input int v, input bit prot);
        return prot && (v == 8 || (v >= 10 && v <= 14) || v == 17);
    endfunction

    // Monitor: scoreboard compare of each write, memory model, read data.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            mem[wr_addr]     = wr_data[7:0];
            mem[wr_addr + 1] = wr_data[15:8];
            if (wr_size) begin
                mem[wr_addr + 2] = wr_data[23:16];
                mem[wr_addr + 3] = wr_data[31:24];
            end
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected write", wr_addr, 32'h0);
            end else begin
                mon_it = exp_q.pop_front();
                check(wr_addr == mon_it.addr, mon_it.tag, "write address", wr_addr, mon_it.addr);
                check(wr_data == mon_it.data && wr_size == mon_it.sz, mon_it.tag,
                      "write data/size", {wr_size, wr_data[30:0]}, {mon_it.sz, mon_it.data[30:0]});
            end
        end
        if (rst_n && rd_en) begin
            rd_cycles++;
            rd_data <= {rdb(rd_addr + 3), rdb(rd_addr + 2), rdb(rd_addr + 1), rdb(rd_addr)};
        end
    end

    // Waits for done and checks its cycle (R7).
    task automatic wait_done(input int exp_cyc, input string tag);
        int n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (done || n >= 40) break;
        end
        check(done && n == exp_cyc, tag, "cycles to done (R7)", 32'(n), 32'(exp_cyc));
    endtask

    task automatic pulse_check();
        @(negedge clk);
        check(!done, "R7", "done pulse width", {31'h0, done}, 32'h0);
    endtask

    // Requests that must be ignored while busy (R8).
    task automatic poke();
        trap_req  = 1'b1;
        iret_req  = 1'b1;
        cur_eip   = 32'hDEAD_BEEF;
        cur_sp    = 32'h5555_0000;
        cur_flags = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        trap_req = 1'b0;
        iret_req = 1'b0;
    endtask

    // Driver: queue expected frame, raise the request, check completion.
    task automatic do_trap(input int vec, input logic [31:0] err, input bit prot,
                           input bit g32, input logic [15:0] cs, input logic [31:0] eip,
                           input logic [31:0] flags, input logic [31:0] sp,
                           input bit do_poke, input bit both, input string tag);
        int          w;
        int          n;
        logic [31:0] m;
        logic [31:0] vals [4];
        logic [31:0] s;
        wr_item_t    it;
        w = (prot && g32) ? 4 : 2;
        m = (w == 4) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        vals[0] = flags & m;
        vals[1] = {16'h0, cs};
        vals[2] = eip & m;
        vals[3] = err & m;
        n = mdl_err(vec, prot) ? 4 : 3;
        s = sp;
        for (int i = 0; i < n; i++) begin
            s = mdl_step(s, prot, w, 1'b0);
            it.addr = s;
            it.data = vals[i];
            it.sz   = (w == 4);
            it.tag  = tag;
            exp_q.push_back(it);
        end
        @(posedge clk);
        #1;
        trap_vec  = 8'(vec);
        trap_err  = err;
        prot_mode = prot;
        gate32    = g32;
        cur_cs    = cs;
        cur_eip   = eip;
        cur_flags = flags;
        cur_sp    = sp;
        trap_req  = 1'b1;
        iret_req  = both;
        @(posedge clk);
        #1;
        trap_req = 1'b0;
        iret_req = 1'b0;
        if (do_poke) begin
            fork
                wait_done(n + 1, tag);
                poke();
            join
        end else begin
            wait_done(n + 1, tag);
        end
        check(sp_new == s, tag, "sp_new after frame", sp_new, s);
        check(!ret_fault, tag, "no fault on trap", {31'h0, ret_fault}, 32'h0);
        check(exp_q.size() == 0, tag, "all slots written", 32'(exp_q.size()), 32'h0);
        pulse_check();
    endtask

    task automatic do_iret(input bit prot, input bit g32, input logic [31:0] sp,
                           input logic [31:0] limit, input logic [31:0] e_eip,
                           input logic [15:0] e_cs, input logic [31:0] e_flags,
                           input bit e_fault, input string tag);
        int          w;
        logic [31:0] s;
        w = (prot && g32) ? 4 : 2;
        s = sp;
        for (int i = 0; i < 3; i++) s = mdl_step(s, prot, w, 1'b1);
        if (e_fault) s = sp;
        @(posedge clk);
        #1;
        prot_mode = prot;
        gate32    = g32;
        cur_sp    = sp;
        cs_limit  = limit;
        iret_req  = 1'b1;
        @(posedge clk);
        #1;
        iret_req = 1'b0;
        wait_done(4, tag);
        check(ret_fault == e_fault, tag, "return fault", {31'h0, ret_fault}, {31'h0, e_fault});
        check(sp_new == s, tag, "sp_new after return", sp_new, s);
        if (!e_fault) begin
            check(ret_eip == e_eip, tag, "restored offset", ret_eip, e_eip);
            check(ret_cs == e_cs, tag, "restored selector", {16'h0, ret_cs}, {16'h0, e_cs});
            check(ret_flags == e_flags, tag, "restored flags", ret_flags, e_flags);
        end
        pulse_check();
    endtask

    // Watchdog: expiry is a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R7", "watchdog expired", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int rc;
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !done && !ret_fault, "R1", "status in reset",
              {29'h0, busy, done, ret_fault}, 32'h0);
        check(!wr_en && !rd_en, "R1", "strobes in reset", {30'h0, wr_en, rd_en}, 32'h0);
        check(sp_new == 32'h0, "R1", "sp_new in reset", sp_new, 32'h0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R3 R2: real-mode fault at offset 10000h, no error code, offset saved as 0.
        do_trap(13, 32'h0000_0018, 1'b0, 1'b0, 16'h1234, 32'h0001_0000,
                32'h0003_0202, 32'h0000_1000, 1'b0, 1'b0, "R3");
        // R9: real-mode return resumes at offset 0.
        do_iret(1'b0, 1'b0, 32'h0000_0FFA, 32'h0000_FFFF, 32'h0, 16'h1234,
                32'h0000_0202, 1'b0, "R9");

        // R6: real-mode stack wraps in the low half, high half kept.
        do_trap(32, 32'h0, 1'b0, 1'b0, 16'h0700, 32'h0000_FFFF,
                32'h0000_0046, 32'hABCD_0000, 1'b0, 1'b0, "R6");

        // R4: 32-bit protected gate, fault vector pushes error code.
        do_trap(13, 32'h0000_0018, 1'b1, 1'b1, 16'h0008, 32'h0001_0000,
                32'h0001_0202, 32'h0020_0000, 1'b0, 1'b0, "R4");
        // R10: return to offset past the limit faults and keeps SP.
        do_iret(1'b1, 1'b1, 32'h001F_FFF4, 32'h0000_FFFF, 32'h0, 16'h0,
                32'h0, 1'b1, "R10");

        // R4 R8: interrupt vector, no error code; requests ignored while busy.
        rc = rd_cycles;
        do_trap(33, 32'hAAAA_AAAA, 1'b1, 1'b1, 16'h0008, 32'h0001_2345,
                32'h0000_0246, 32'h0030_0000, 1'b1, 1'b0, "R8");
        check(rd_cycles == rc, "R8", "no reads from ignored return", 32'(rd_cycles), 32'(rc));
        repeat (3) @(negedge clk);
        check(!busy && exp_q.size() == 0, "R8", "idle after ignored requests",
              {31'h0, busy}, 32'h0);
        // R9: protected 32-bit return within the limit.
        do_iret(1'b1, 1'b1, 32'h002F_FFF4, 32'h000F_FFFF, 32'h0001_2345, 16'h0008,
                32'h0000_0246, 1'b0, "R9");

        // R5: 16-bit protected gate, page-fault vector, error code trimmed.
        do_trap(14, 32'h0001_2345, 1'b1, 1'b0, 16'h0010, 32'h0001_2340,
                32'h0001_0202, 32'h0040_0000, 1'b0, 1'b0, "R5");
        do_iret(1'b1, 1'b0, 32'h003F_FFFA, 32'h0000_FFFF, 32'h0000_2340, 16'h0010,
                32'h0000_0202, 1'b0, "R5");

        // R11: real-mode return above the limit does not fault.
        put16(32'h0000_3000, 16'h8000);
        put16(32'h0000_3002, 16'h0040);
        put16(32'h0000_3004, 16'h0046);
        do_iret(1'b0, 1'b1, 32'h0000_3000, 32'h0000_0100, 32'h0000_8000, 16'h0040,
                32'h0000_0046, 1'b0, "R11");

        // R8: trap and return together while idle, trap wins.
        rc = rd_cycles;
        do_trap(0, 32'h0, 1'b1, 1'b1, 16'h0018, 32'h0000_4000,
                32'h0000_0002, 32'h0050_0000, 1'b0, 1'b1, "R8");
        check(rd_cycles == rc, "R8", "trap wins over return", 32'(rd_cycles), 32'(rc));

        // R2: one more real-mode frame from an odd-looking pointer.
        do_trap(8, 32'h0000_0000, 1'b0, 1'b1, 16'hF000, 32'h0000_E05B,
                32'h0000_0000, 32'h0000_0002, 1'b0, 1'b0, "R2");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule